// File: doc/BRIEF.md
# FPGA configuration control sequencer

This block sits between a host register bus and the configuration pins of a target FPGA. Software writes a control word that enables the sequencer, drives the chip-enable and reconfiguration pins, selects an output width and a clock-to-data ratio, and opens a window for configuration data. A status word reports the current configuration phase. It also reports the mode-select strap value on the board, whether that value is legal, and the width and ratio that value calls for.

Configuration words arrive on a 32-bit write port with a ready/valid handshake. Each accepted word is sent out on the data pins. At full width it goes out whole. At half width it goes out as two halves, low half first. Each output value is held for 1, 2, 4 or 8 data-clock periods. One data-clock period is two system clocks, and the data changes while the data clock is low. A phase tracker follows the reconfiguration pull, the done pin and the status pin. It moves through power-up, reset, configuration, init and user mode.

Top module: `cfg_seq_top`

## Requirements
- R1: After reset the control word reads 0x2, the phase field reads 0 (power-up), `ncfg_o` and `nce_o` are 1, `dat_ready` is 0 and `dclk_o` is 0.
- R2: Control word (address 0x4) bits 0 (enable), 1 (chip enable, active low), 2 (reconfig pull), 7:6 (ratio), 8 (data window) and 9 (width, 1 = 32-bit) are writable. All other bits read 0. `nce_o` follows bit 1.
- R3: `ncfg_o` is 0 exactly while both enable and pull are 1. The phase field (status address 0x0, bits 2:0) reads 1 (reset) at the second clock edge after such a write. Pull with enable 0 leaves the phase unchanged.
- R4: In reset, once enable and pull are not both set, the phase becomes 2 (configuration) at the next edge.
- R5: In configuration, while `conf_done_i` is high and the data window bit is 0, the phase becomes 3 (init) and then 4 (user mode) on the following edge. With the window bit set, the phase stays 2.
- R6: In configuration, init or user mode, `nstatus_i` low returns the phase to 1 at the next edge.
- R7: Status bits 7:3 mirror `msel_i`. Bit 8 flags an illegal value: anything other than 0,1,2,4,5,6,8,9,10,12,13,14. Bit 11 gives the width (1 for values 8 to 14). Bits 10:9 give the ratio code: 0 for values ending in binary 00; 1 for 1 and 5; 2 for 2, 6, 9 and 13; 3 for 10 and 14. An illegal value reports 0 in bits 11:9.
- R8: `dat_ready` is 0 while the data window bit is 0 or a word is still being sent. A word is taken only on a clock edge with `dat_valid` and `dat_ready` both high.
- R9: In 32-bit mode, with ratio code r and n = 2^r, an accepted word appears on `cfg_data_o` for n rising edges of `dclk_o`. `dclk_o` rises once every two clocks.
- R10: In 16-bit mode, `cfg_data_o` shows the low half zero-extended for n rising edges, then the high half zero-extended for n rising edges.
- R11: `dat_ready` is observed high again 2·n·beats+1 clock sampling points after the accepting edge, where beats is 1 in 32-bit mode and 2 in 16-bit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address (0x0 status, 0x4 control) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| dat_valid | input | 1 | Configuration word valid |
| dat_word | input | 32 | Configuration word |
| dat_ready | output | 1 | Sequencer can take a word |
| msel_i | input | 5 | Mode-select strap value |
| nstatus_i | input | 1 | Target status pin, low on error or reset |
| conf_done_i | input | 1 | Target configuration-done pin |
| ncfg_o | output | 1 | Reconfiguration pin, active low |
| nce_o | output | 1 | Target chip enable, active low |
| cfg_data_o | output | 32 | Configuration data pins |
| dclk_o | output | 1 | Configuration data clock |

## Verification
The bench walks all 32 strap values and compares each against a separately written decode. A design that mixed up the width groups or the encrypted and compressed ratios would report the wrong width or ratio code. It also checks that pull without enable leaves the phase alone; a design that ignored enable would drop into reset. The bench asserts the done pin while the data window is still open, where a design with a wrong exit condition would leave configuration early. Streaming tests use the slowest and fastest ratios and a half-width word whose high half is zero. A wrong hold count shows up as a wrong number of data-clock edges, a swapped half order as swapped data values, and a wrong busy length as a wrong interval before ready returns.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    typedef enum logic [2:0] {
        PH_PWRUP   = 3'd0,
        PH_RESET   = 3'd1,
        PH_CONFIG  = 3'd2,
        PH_INIT    = 3'd3,
        PH_USER    = 3'd4,
        PH_UNKNOWN = 3'd5
    } phase_e;

    localparam int CTL_EN     = 0;
    localparam int CTL_NCE    = 1;
    localparam int CTL_PULL   = 2;
    localparam int CTL_RAT_LO = 6;
    localparam int CTL_XFER   = 8;
    localparam int CTL_WIDE   = 9;

    localparam logic [31:0] CTL_MASK  = 32'h0000_03C7;
    localparam logic [31:0] CTL_RESET = 32'h0000_0002;

    typedef struct packed {
        logic       wide;
        logic [1:0] ratio;
        logic       bad;
    } mode_t;

endpackage

// File: rtl/cfg_seq_msel.sv
module cfg_seq_msel #(
    parameter int MSEL_W = 5
) (
    input  logic [MSEL_W-1:0]      msel,
    output cfg_seq_pkg::mode_t     mode
);
    import cfg_seq_pkg::*;

    logic [1:0] sub;
    logic       upper_set;

    always_comb begin
        sub       = msel[1:0];
        upper_set = (msel[MSEL_W-1:4] != '0);
        mode      = '0;
        if (upper_set || sub == 2'd3) begin
            mode.bad = 1'b1;
        end else begin
            mode.wide = msel[3];
            if (sub == 2'd0) mode.ratio = 2'd0;
            else             mode.ratio = sub + {1'b0, msel[3]};
        end
    end

endmodule

// File: rtl/cfg_seq_regs.sv
module cfg_seq_regs #(
    parameter int ADDR_W = 4,
    parameter int MSEL_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    input  cfg_seq_pkg::phase_e phase,
    input  cfg_seq_pkg::mode_t  mode,
    input  logic [MSEL_W-1:0]  msel,
    output logic               en,
    output logic               nce,
    output logic               pull,
    output logic [1:0]         ratio,
    output logic               xfer,
    output logic               wide
);
    import cfg_seq_pkg::*;

    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(4);

    typedef struct packed {
        logic [31:0] ctrl;
    } regs_t;

    regs_t st_q, st_d;
    logic [31:0] status;

    always_comb begin
        st_d = st_q;
        if (wr && addr == CTRL_ADDR)
            st_d.ctrl = wdata & CTL_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ctrl: CTL_RESET};
        else        st_q <= st_d;
    end

    always_comb begin
        status        = '0;
        status[2:0]   = phase;
        status[3 +: MSEL_W] = msel;
        status[8]     = mode.bad;
        status[10:9]  = mode.ratio;
        status[11]    = mode.wide;
        if (addr == STAT_ADDR)      rdata = status;
        else if (addr == CTRL_ADDR) rdata = st_q.ctrl;
        else                        rdata = '0;
    end

    assign en    = st_q.ctrl[CTL_EN];
    assign nce   = st_q.ctrl[CTL_NCE];
    assign pull  = st_q.ctrl[CTL_PULL];
    assign ratio = st_q.ctrl[CTL_RAT_LO +: 2];
    assign xfer  = st_q.ctrl[CTL_XFER];
    assign wide  = st_q.ctrl[CTL_WIDE];

endmodule

// File: rtl/cfg_seq_phase.sv
module cfg_seq_phase (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                pull,
    input  logic                xfer,
    input  logic                nstatus,
    input  logic                conf_done,
    output cfg_seq_pkg::phase_e phase
);
    import cfg_seq_pkg::*;

    phase_e phase_d, phase_q;
    logic   hold_rst;

    always_comb begin
        hold_rst = en & pull;
        phase_d  = phase_q;
        if (hold_rst) begin
            phase_d = PH_RESET;
        end else begin
            case (phase_q)
                PH_RESET:  phase_d = PH_CONFIG;
                PH_CONFIG: begin
                    if (!nstatus)              phase_d = PH_RESET;
                    else if (conf_done && !xfer) phase_d = PH_INIT;
                end
                PH_INIT:   phase_d = nstatus ? PH_USER : PH_RESET;
                PH_USER:   if (!nstatus) phase_d = PH_RESET;
                default:   phase_d = phase_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_PWRUP;
        else        phase_q <= phase_d;
    end

    assign phase = phase_q;

    // R3: an effective pull forces reset
    a_r3_pull_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (en && pull) |=> (phase_q == PH_RESET));

    // R5: init always advances to user mode when undisturbed
    a_r5_init_user: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_INIT && nstatus && !(en && pull)) |=> (phase_q == PH_USER));

    // R6: status drop returns to reset
    a_r6_nstatus_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (!nstatus && (phase_q == PH_CONFIG || phase_q == PH_INIT || phase_q == PH_USER))
        |=> (phase_q == PH_RESET));

endmodule

// File: rtl/cfg_seq_ser.sv
module cfg_seq_ser #(
    parameter int DATA_W  = 32,
    parameter int RATIO_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               xfer_en,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               wide,
    input  logic               valid,
    input  logic [DATA_W-1:0]  word,
    output logic               ready,
    output logic [DATA_W-1:0]  data_o,
    output logic               dclk_o
);
    localparam int HALF  = DATA_W / 2;
    localparam int CNT_W = 1 << RATIO_W;

    typedef struct packed {
        logic               busy;
        logic               second;
        logic               wide;
        logic [RATIO_W-1:0] ratio;
        logic [CNT_W-1:0]   cnt;
        logic [DATA_W-1:0]  data;
        logic [HALF-1:0]    upper;
    } ser_t;

    ser_t q, d;
    logic [CNT_W-1:0] term;

    always_comb begin
        d     = q;
        term  = CNT_W'((32'd2 << q.ratio) - 32'd1);
        ready = xfer_en & ~q.busy;
        if (!q.busy) begin
            if (valid && ready) begin
                d.busy   = 1'b1;
                d.cnt    = '0;
                d.wide   = wide;
                d.ratio  = ratio;
                d.second = ~wide;
                d.data   = wide ? word : {{HALF{1'b0}}, word[HALF-1:0]};
                d.upper  = word[DATA_W-1:HALF];
            end
        end else if (q.cnt == term) begin
            if (q.second) begin
                d.second = 1'b0;
                d.cnt    = '0;
                d.data   = {{HALF{1'b0}}, q.upper};
            end else begin
                d.busy = 1'b0;
            end
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign data_o = q.data;
    assign dclk_o = q.busy & q.cnt[0];

    // R9: data holds for the whole beat
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.cnt != term) |=> $stable(q.data));

    // R10: half-width beats never carry upper bits
    a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && !q.wide) |-> (q.data[DATA_W-1:HALF] == '0));

endmodule

// File: rtl/cfg_seq_top.sv
module cfg_seq_top #(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int MSEL_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              dat_valid,
    input  logic [DATA_W-1:0] dat_word,
    output logic              dat_ready,
    input  logic [MSEL_W-1:0] msel_i,
    input  logic              nstatus_i,
    input  logic              conf_done_i,
    output logic              ncfg_o,
    output logic              nce_o,
    output logic [DATA_W-1:0] cfg_data_o,
    output logic              dclk_o
);
    import cfg_seq_pkg::*;

    phase_e     phase;
    mode_t      mode;
    logic       en, nce, pull, xfer, wide;
    logic [1:0] ratio;

    cfg_seq_msel #(.MSEL_W(MSEL_W)) msel_i0 (
        .msel (msel_i),
        .mode (mode)
    );

    cfg_seq_regs #(.ADDR_W(ADDR_W), .MSEL_W(MSEL_W)) regs_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .phase (phase),
        .mode  (mode),
        .msel  (msel_i),
        .en    (en),
        .nce   (nce),
        .pull  (pull),
        .ratio (ratio),
        .xfer  (xfer),
        .wide  (wide)
    );

    cfg_seq_phase phase_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .pull      (pull),
        .xfer      (xfer),
        .nstatus   (nstatus_i),
        .conf_done (conf_done_i),
        .phase     (phase)
    );

    cfg_seq_ser #(.DATA_W(DATA_W), .RATIO_W(2)) ser_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .xfer_en (xfer),
        .ratio   (ratio),
        .wide    (wide),
        .valid   (dat_valid),
        .word    (dat_word),
        .ready   (dat_ready),
        .data_o  (cfg_data_o),
        .dclk_o  (dclk_o)
    );

    assign ncfg_o = ~(en & pull);
    assign nce_o  = nce;

endmodule

// File: tb/cfg_seq_top_tb_top.sv
module cfg_seq_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dat_valid = 1'b0;
    logic [31:0] dat_word = '0;
    logic        dat_ready;
    logic [4:0]  msel_i = 5'd0;
    logic        nstatus_i = 1'b1;
    logic        conf_done_i = 1'b0;
    logic        ncfg_o, nce_o, dclk_o;
    logic [31:0] cfg_data_o;

    int nrun = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    cfg_seq_top dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dat_valid(dat_valid),
        .dat_word(dat_word), .dat_ready(dat_ready), .msel_i(msel_i),
        .nstatus_i(nstatus_i), .conf_done_i(conf_done_i), .ncfg_o(ncfg_o),
        .nce_o(nce_o), .cfg_data_o(cfg_data_o), .dclk_o(dclk_o)
    );

    // capture data value at every rising data-clock edge
    logic [31:0] cap [0:63];
    int   ncap = 0;
    logic prev_dclk = 1'b0;
    always @(negedge clk) begin
        if (dclk_o && !prev_dclk && ncap < 64) begin
            cap[ncap] = cfg_data_o;
            ncap = ncap + 1;
        end
        prev_dclk = dclk_o;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nrun++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(4'h4, v); check("R1 ctrl", v, 32'h2);
        rd(4'h0, v); check("R1 status", v, 32'h0);
        check("R1 ncfg", {31'b0, ncfg_o}, 32'd1);
        check("R1 nce", {31'b0, nce_o}, 32'd1);
        check("R1 ready", {31'b0, dat_ready}, 32'd0);
        check("R1 dclk", {31'b0, dclk_o}, 32'd0);
    endtask

    task automatic t_pull_no_en;
        logic [31:0] v;
        wr(4'h4, 32'h4);
        @(negedge clk);
        rd(4'h0, v); check("R3 pull without enable phase", {29'b0, v[2:0]}, 32'd0);
        check("R3 pull without enable ncfg", {31'b0, ncfg_o}, 32'd1);
    endtask

    task automatic t_ctrl_bits;
        logic [31:0] v;
        wr(4'h4, 32'hFFFF_FFFF);
        rd(4'h4, v); check("R2 writable mask", v, 32'h3C7);
        check("R2 nce high", {31'b0, nce_o}, 32'd1);
        check("R3 ncfg low", {31'b0, ncfg_o}, 32'd0);
        wr(4'h4, 32'h0);
        rd(4'h4, v); check("R2 cleared", v, 32'h0);
        check("R2 nce low", {31'b0, nce_o}, 32'd0);
        check("R3 ncfg released", {31'b0, ncfg_o}, 32'd1);
    endtask

    task automatic t_phases;
        logic [31:0] v;
        wr(4'h4, 32'h5);
        @(negedge clk);
        rd(4'h0, v); check("R3 reset phase", {29'b0, v[2:0]}, 32'd1);
        wr(4'h4, 32'h101);
        @(negedge clk);
        rd(4'h0, v); check("R4 config phase", {29'b0, v[2:0]}, 32'd2);
        conf_done_i = 1'b1;
        repeat (3) @(negedge clk);
        rd(4'h0, v); check("R5 window open stays config", {29'b0, v[2:0]}, 32'd2);
        wr(4'h4, 32'h1);
        @(negedge clk);
        rd(4'h0, v); check("R5 init phase", {29'b0, v[2:0]}, 32'd3);
        @(negedge clk);
        rd(4'h0, v); check("R5 user phase", {29'b0, v[2:0]}, 32'd4);
        nstatus_i = 1'b0;
        @(negedge clk);
        rd(4'h0, v); check("R6 nstatus drop", {29'b0, v[2:0]}, 32'd1);
        nstatus_i = 1'b1;
        conf_done_i = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [8:0] exp_msel(input int m);
        logic       bad, w;
        logic [1:0] r;
        bad = 1'b0; w = 1'b0; r = 2'd0;
        case (m)
            0, 4:   begin w = 0; r = 0; end
            1, 5:   begin w = 0; r = 1; end
            2, 6:   begin w = 0; r = 2; end
            8, 12:  begin w = 1; r = 0; end
            9, 13:  begin w = 1; r = 2; end
            10, 14: begin w = 1; r = 3; end
            default: bad = 1'b1;
        endcase
        return {w, r, bad, 5'(m)};
    endfunction

    task automatic t_msel;
        logic [31:0] v;
        for (int m = 0; m < 32; m++) begin
            msel_i = 5'(m);
            rd(4'h0, v);
            check($sformatf("R7 strap %0d", m), {23'b0, v[11:3]}, {23'b0, exp_msel(m)});
        end
        msel_i = 5'd0;
    endtask

    task automatic t_closed_window;
        int base;
        wr(4'h4, 32'h201);
        base = ncap;
        dat_word = 32'hDEAD_BEEF;
        dat_valid = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check("R8 ready low with window closed", {31'b0, dat_ready}, 32'd0);
        end
        dat_valid = 1'b0;
        check("R8 nothing sent", 32'(ncap - base), 32'd0);
    endtask

    task automatic t_send(input logic w, input int r, input logic [31:0] word, input string tag);
        int n, beats, base, c, k;
        logic [31:0] hv;
        n = 1 << r;
        beats = w ? 1 : 2;
        wr(4'h4, 32'h101 | (32'(r) << 6) | (32'(w) << 9));
        base = ncap;
        dat_word = word;
        dat_valid = 1'b1;
        c = 0;
        while (!dat_ready && c < 100) begin @(negedge clk); c++; end
        c = 0;
        do begin
            @(negedge clk);
            dat_valid = 1'b0;
            if (c == 0) check({"R8 ready low while busy ", tag}, {31'b0, dat_ready}, 32'd0);
            c++;
        end while (!dat_ready && c < 200);
        check({"R11 busy length ", tag}, 32'(c), 32'(2 * n * beats + 1));
        check({tag, " edge count"}, 32'(ncap - base), 32'(n * beats));
        k = 0;
        for (int b = 0; b < beats; b++) begin
            if (w)          hv = word;
            else if (b == 0) hv = {16'h0, word[15:0]};
            else            hv = {16'h0, word[31:16]};
            for (int i = 0; i < n; i++) begin
                if (base + k < 64) check({tag, " data"}, cap[base + k], hv);
                k++;
            end
        end
    endtask

    initial begin
        #800000;
        nfail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", nrun, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pull_no_en();
        t_ctrl_bits();
        t_phases();
        t_msel();
        t_closed_window();
        t_send(1'b1, 0, 32'h1234_5678, "R9 wide x1");
        t_send(1'b1, 3, 32'hCAFE_F00D, "R9 wide x8");
        t_send(1'b0, 1, 32'hA5A5_3C3C, "R10 half x2");
        t_send(1'b0, 2, 32'h0000_00AB, "R10 half x4 partial");
        t_send(1'b0, 0, 32'h8001_7FFE, "R10 half x1");
        $display("[TB] %0d tests run, %0d failed", nrun, nfail);
        $finish;
    end

endmodule